// File: doc/BRIEF.md
# Multi-Lane Pixel Serializer Framer

This block turns a stream of 27-bit parallel pixel words into 30-bit serial frames. Each frame begins with a parity bit, carries the 27 data bits from the most significant bit down, and ends in two reserved bits held at zero. The frame is spread over one, two or three serial data lanes. Next to them runs a clock lane that stays high for the first half of every frame period and low for the second half, so the far end can find the frame boundary.

The block runs on a single bit-rate clock `clk`, and each active lane moves one bit per `clk` cycle. The pixel clock comes in as an ordinary signal. It is sampled on `clk`, and a chosen transition of it (rising or falling) captures the data word. The user supplies a pixel clock whose period is 30, 15 or 10 `clk` cycles for one, two or three lanes. The lane count and the lane-swap setting are latched together with each word. The lane-swap setting mirrors the physical order of the four lane outputs, so board routing can cross over without skew.

Top module: `pix_lane_serializer`

## Requirements
- R1: With `pix_pol`=1 a word is captured at the first `clk` edge that samples `pix_clk` high after it was sampled low. With `pix_pol`=0 the capture happens on a high-to-low transition instead. The outputs show frame slot 0 right after the capturing `clk` edge.
- R2: Frame bit t (transmit order) is the parity bit for t=0. The parity bit is 1 when the word has an even number of ones and 0 when it has an odd number. For t=1..27 bit t is data bit 27-t. Bits t=28 and t=29 are 0.
- R3: `lane_sel` 00, 01 and 10 select N=1, 2 and 3 lanes, which gives S=30, 15 and 10 slots per frame. Frame bit t goes out on lane t mod N during slot t div N, one slot per `clk` cycle.
- R4: A word captured while `lane_sel`=11 produces no frame. All four outputs stay 0 until the next capture with a valid selection.
- R5: Lanes with an index of N or higher are driven 0 throughout an active frame.
- R6: During an active frame the clock lane is 1 in every slot s with 2·s < S, and 0 in the other slots.
- R7: With the latched swap setting at 1, output `ser_o[0]` carries lane 2, `ser_o[2]` carries lane 0, `ser_o[1]` carries the clock lane and `frm_clk_o` carries lane 1. With the setting at 0 the mapping is straight.
- R8: After reset, and after the last slot of a frame when no new capture follows, all outputs are 0. A capture that lands in the cycle after the last slot starts the next frame without a gap.
- R9: Changes on `lane_sel` and `lane_swap` between captures have no effect on the frame that is already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one serial bit per lane per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on `clk` |
| pix_data | input | 27 | Parallel pixel word |
| pix_pol | input | 1 | Capture edge: 1 rising, 0 falling |
| lane_sel | input | 2 | Lane count: 00 one, 01 two, 10 three, 11 forbidden |
| lane_swap | input | 1 | 1 mirrors the lane output order |
| ser_o | output | 3 | Serial data lane outputs |
| frm_clk_o | output | 1 | Frame clock lane output |

## Verification
The bench aims at the words whose parity is easy to invert: all zeros (parity 1), all ones (27 ones, parity 0) and alternating patterns. A design with inverted parity shows the wrong first bit on lane 0. It also checks the odd slot count of the two-lane mode, where the clock lane has to stay high for eight slots and not seven. It sends frames back to back, so an off-by-one in the slot counter either drops the last reserved bit or leaves a gap. Further cases cover a forbidden lane selection, a swap and a lane-count change in the middle of a frame, and a capture on the falling pixel-clock edge. In those cases a design that used the live inputs, or the wrong edge, would scramble the lane order or shift the frame by half a pixel period.

// File: rtl/pxs_pkg.sv
`timescale 1ns/100ps
// Shared constants for the pixel lane serializer.
// Assumes the frame is at least one bit longer than the pixel word.
package pxs_pkg;
    localparam int PIX_W     = 27;
    localparam int FRAME_W   = 30;
    localparam int MAX_LANES = 3;
endpackage

// File: rtl/pxs_frame_build.sv
`timescale 1ns/100ps
// Builds the transmit-order frame from one pixel word: bit 0 is the
// parity bit (1 when the word holds an even count of ones), then the data
// from its MSB down, then zero padding. Purely combinational.
module pxs_frame_build #(
    parameter int DATA_W  = pxs_pkg::PIX_W,
    parameter int FRAME_W = pxs_pkg::FRAME_W
) (
    input  logic [DATA_W-1:0]  word_i,
    output logic [FRAME_W-1:0] frame_o
);
    // Assemble parity, reversed data and zero padding.
    always_comb begin
        frame_o    = '0;
        frame_o[0] = ~^word_i;
        for (int i = 0; i < DATA_W; i++) begin
            frame_o[1+i] = word_i[DATA_W-1-i];
        end
    end
endmodule

// File: rtl/pxs_lane_pick.sv
`timescale 1ns/100ps
// Selects, for every lane, the frame bit due in the current slot. Bits go
// round-robin: lane l in slot s carries frame bit s*n+l. Lanes at or above
// the active count n, and indexes past the frame end, give 0.
module pxs_lane_pick #(
    parameter int FRAME_W = pxs_pkg::FRAME_W,
    parameter int LANES   = pxs_pkg::MAX_LANES,
    parameter int CNT_W   = $clog2(FRAME_W + 1),
    parameter int N_W     = $clog2(LANES + 1)
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   slot_i,
    input  logic [N_W-1:0]     n_i,
    output logic [LANES-1:0]   bits_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Pick the frame bit for lane l in the current slot.
        always_comb begin
            int idx;
            idx       = int'(slot_i) * int'(n_i) + l;
            bits_o[l] = 1'b0;
            for (int k = 0; k < FRAME_W; k++) begin
                if (l < int'(n_i) && idx == k) bits_o[l] = frame_i[k];
            end
        end
    end
endmodule

// File: rtl/pxs_swap.sv
`timescale 1ns/100ps
// Mirrors a row of output positions when swap_i is high, straight through
// otherwise. The caller orders the row as the physical pin order.
module pxs_swap #(
    parameter int W = pxs_pkg::MAX_LANES + 1
) (
    input  logic         swap_i,
    input  logic [W-1:0] row_i,
    output logic [W-1:0] row_o
);
    for (genvar i = 0; i < W; i++) begin : g_pos
        // Position i takes its mirror partner when swapped.
        assign row_o[i] = swap_i ? row_i[W-1-i] : row_i[i];
    end
endmodule

// File: rtl/pix_lane_serializer.sv
`timescale 1ns/100ps
// Pixel lane serializer top. Samples pix_clk on the bit-rate clock, and
// captures a word on the chosen transition, together with the lane count
// and the swap setting. It then sends one frame slot per cycle. Assumes
// LANES >= 2 (clock lane sits between lane 0 and lane 1 in the pin row)
// and a pixel period of FRAME_W/N clk cycles. Sync active-low reset.
module pix_lane_serializer #(
    parameter int DATA_W  = pxs_pkg::PIX_W,
    parameter int FRAME_W = pxs_pkg::FRAME_W,
    parameter int LANES   = pxs_pkg::MAX_LANES,
    parameter int SEL_W   = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_clk,
    input  logic [DATA_W-1:0] pix_data,
    input  logic             pix_pol,
    input  logic [SEL_W-1:0] lane_sel,
    input  logic             lane_swap,
    output logic [LANES-1:0] ser_o,
    output logic             frm_clk_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int N_W   = SEL_W;
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(LANES - 1);

    logic               pclk_q;
    logic               cap;
    logic               sel_ok;
    logic [N_W-1:0]     n_next;
    logic [CNT_W-1:0]   slots_next;
    logic [FRAME_W-1:0] frame_w;
    logic [FRAME_W-1:0] frame_q;
    logic [N_W-1:0]     n_q;
    logic [CNT_W-1:0]   slots_q;
    logic [CNT_W-1:0]   slot_q;
    logic               swap_q;
    logic               act_q;
    logic [LANES-1:0]   lanes_raw;
    logic [LANES-1:0]   lanes_g;
    logic               clk_g;
    logic [LANES:0]     row_in;
    logic [LANES:0]     row_out;

    // Detect the selected pixel-clock transition.
    assign cap = pix_pol ? (pix_clk & ~pclk_q) : (~pix_clk & pclk_q);

    // Decode the lane selection into a lane count and slot count.
    always_comb begin
        int div;
        sel_ok     = (lane_sel <= SEL_MAX);
        n_next     = N_W'(lane_sel) + N_W'(1);
        div        = (n_next == '0) ? 1 : int'(n_next);
        slots_next = CNT_W'((FRAME_W + div - 1) / div);
    end

    pxs_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_build (
        .word_i (pix_data),
        .frame_o(frame_w)
    );

    // Capture a frame on a pixel edge, else step through its slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_q  <= 1'b0;
            frame_q <= '0;
            n_q     <= '0;
            slots_q <= '0;
            slot_q  <= '0;
            swap_q  <= 1'b0;
            act_q   <= 1'b0;
        end else begin
            pclk_q <= pix_clk;
            if (cap) begin
                frame_q <= frame_w;
                n_q     <= n_next;
                slots_q <= slots_next;
                swap_q  <= lane_swap;
                slot_q  <= '0;
                act_q   <= sel_ok;
            end else if (act_q) begin
                if (slot_q == slots_q - CNT_W'(1)) act_q  <= 1'b0;
                else                               slot_q <= slot_q + CNT_W'(1);
            end
        end
    end

    pxs_lane_pick #(.FRAME_W(FRAME_W), .LANES(LANES), .CNT_W(CNT_W), .N_W(N_W)) u_pick (
        .frame_i(frame_q),
        .slot_i (slot_q),
        .n_i    (n_q),
        .bits_o (lanes_raw)
    );

    // Gate lanes while idle and form the half-period frame clock.
    always_comb begin
        lanes_g = act_q ? lanes_raw : '0;
        clk_g   = act_q && ({slot_q, 1'b0} < {1'b0, slots_q});
        row_in  = {lanes_g[LANES-1:1], clk_g, lanes_g[0]};
    end

    pxs_swap #(.W(LANES + 1)) u_swap (
        .swap_i(swap_q),
        .row_i (row_in),
        .row_o (row_out)
    );

    assign ser_o     = {row_out[LANES:2], row_out[0]};
    assign frm_clk_o = row_out[1];

    // R2: the first slot after a valid straight capture carries the parity.
    assert_parity_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && sel_ok && !lane_swap) |=> (ser_o[0] == ~^$past(pix_data)));
    // R3: the slot counter never leaves the frame.
    assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (slot_q < slots_q));
    // R4: a forbidden selection leaves every output low.
    assert_forbidden_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !sel_ok) |=> (ser_o == '0 && !frm_clk_o));
    // R5: in one-lane mode the upper lanes stay low.
    assert_unused_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && n_q == N_W'(1) && !swap_q) |-> (ser_o[LANES-1:1] == '0));
    // R6: the frame clock starts high.
    assert_clock_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && sel_ok && !lane_swap) |=> frm_clk_o);
    // R7: swapped, the parity moves to the far lane and the clock to lane 1.
    assert_swap_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && sel_ok && lane_swap) |=> (ser_o[LANES-1] == ~^$past(pix_data) && ser_o[1]));
    // R8: the cycle after the last slot with no capture is idle.
    assert_idle_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && slot_q == slots_q - CNT_W'(1) && !cap) |=> (ser_o == '0 && !frm_clk_o));
endmodule

// File: tb/pix_lane_serializer_bench.sv
`timescale 1ns/100ps
// Self-checking bench: a behavioural model tracks the expected frame and
// is compared to the outputs one time step after every clk rising edge.
module pix_lane_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_clk = 1'b0;
    logic [26:0] pix_data = '0;
    logic        pix_pol = 1'b1;
    logic [1:0]  lane_sel = 2'b00;
    logic        lane_swap = 1'b0;
    logic [2:0]  ser_o;
    logic        frm_clk_o;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R8";

    // Model state
    int          m_act = 0, m_slot = 0, m_n = 1, m_s = 30;
    logic [26:0] m_word = '0;
    bit          m_sw = 0;
    logic        m_prev = 1'b0;

    pix_lane_serializer u_pix_lane_serializer (
        .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .pix_data(pix_data),
        .pix_pol(pix_pol), .lane_sel(lane_sel), .lane_swap(lane_swap),
        .ser_o(ser_o), .frm_clk_o(frm_clk_o)
    );

    always #2.5 clk = ~clk;

    // Frame bit t in transmit order (R2).
    function automatic logic fbit(logic [26:0] w, int t);
        if (t == 0) return ~^w;
        if (t <= 27) return w[27-t];
        return 1'b0;
    endfunction

    // Model update at each clock edge.
    always @(posedge clk) begin
        bit edge_seen;
        edge_seen = pix_pol ? (pix_clk && !m_prev) : (!pix_clk && m_prev);
        if (!rst_n) begin
            m_act = 0; m_slot = 0; m_prev = 1'b0; m_word = '0; m_sw = 0;
        end else begin
            if (edge_seen) begin
                m_word = pix_data;
                m_sw   = lane_swap;
                m_slot = 0;
                if (lane_sel == 2'b11) m_act = 0;
                else begin
                    m_act = 1; m_n = lane_sel + 1; m_s = 30 / m_n;
                end
            end else if (m_act != 0) begin
                if (m_slot == m_s - 1) m_act = 0;
                else m_slot++;
            end
            m_prev = pix_clk;
        end
    end

    // Compare outputs one step after each edge.
    always @(posedge clk) begin
        logic [2:0] lanes, exp_ser;
        logic       ck, exp_ck;
        #1;
        lanes = '0; ck = 1'b0;
        if (m_act != 0) begin
            for (int l = 0; l < 3; l++)
                lanes[l] = (l < m_n) ? fbit(m_word, m_slot * m_n + l) : 1'b0;
            ck = (2 * m_slot < m_s);
        end
        if (m_sw) begin exp_ser = {lanes[0], ck, lanes[2]}; exp_ck = lanes[1]; end
        else      begin exp_ser = lanes;                    exp_ck = ck;       end
        checks++;
        if (ser_o !== exp_ser) begin
            fails++;
            $display("FAIL %s ser_o actual %b expected %b at %0t", cur_req, ser_o, exp_ser, $time);
        end
        checks++;
        if (frm_clk_o !== exp_ck) begin
            fails++;
            $display("FAIL %s frm_clk_o actual %b expected %b at %0t", cur_req, frm_clk_o, exp_ck, $time);
        end
    end

    // One pixel period of S cycles; optional mid-frame control change (R9).
    task automatic send_pixel(logic [26:0] d, logic [1:0] sel, bit sw, bit mid);
        int s_len, hi;
        s_len = (sel == 2'b11) ? 10 : 30 / (sel + 1);
        hi    = s_len / 2;
        pix_data  = d;
        lane_sel  = sel;
        lane_swap = sw;
        pix_clk   = pix_pol;
        repeat (hi) @(negedge clk);
        if (mid) begin
            lane_sel  = (sel == 2'b00) ? 2'b10 : 2'b00;
            lane_swap = ~sw;
        end
        pix_clk = ~pix_pol;
        repeat (s_len - hi) @(negedge clk);
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic stream(logic [1:0] sel, bit sw);
        send_pixel(27'h0000000, sel, sw, 0);
        send_pixel(27'h7FFFFFF, sel, sw, 0);
        send_pixel(27'h2AAAAAA, sel, sw, 0);
        send_pixel(27'h5555555, sel, sw, 0);
        send_pixel(27'h4000001, sel, sw, 0);
        send_pixel(27'h1234567, sel, sw, 0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        cur_req = "R8";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        // R1 R2 R3 R6: rising capture, one lane
        cur_req = "R2";
        stream(2'b00, 0);
        // R5 R6: two lanes, odd slot count
        cur_req = "R6";
        stream(2'b01, 0);
        // R3: three lanes
        cur_req = "R3";
        stream(2'b10, 0);
        // R8: gap after the last frame
        cur_req = "R8";
        idle(20);
        // R7: swapped mapping, three and one lanes
        cur_req = "R7";
        stream(2'b10, 1);
        send_pixel(27'h3C3C3C3, 2'b00, 1, 0);
        // R4: forbidden selection
        cur_req = "R4";
        send_pixel(27'h7FFFFFF, 2'b11, 0, 0);
        send_pixel(27'h1555555, 2'b11, 1, 0);
        // R9: controls changed mid-frame
        cur_req = "R9";
        send_pixel(27'h6DB6DB6, 2'b00, 0, 1);
        send_pixel(27'h1248124, 2'b10, 1, 1);
        send_pixel(27'h0F0F0F0, 2'b01, 0, 1);
        idle(12);
        // R1: falling-edge capture
        cur_req = "R1";
        pix_pol = 1'b0;
        pix_clk = 1'b1;
        idle(5);
        stream(2'b01, 0);
        stream(2'b10, 1);
        cur_req = "R5";
        send_pixel(27'h7FFFFFF, 2'b00, 0, 0);
        idle(35);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule